// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 32x32 pointer image over a stream of display pixels. Software programs, through a 32-bit register port, where the pointer sits and what it looks like. The look is given as two bit planes: a coverage plane, which says which pointer pixels are opaque, and a colour plane, which picks one of two pointer colours for each opaque pixel. Each pixel the display pipeline presents comes with its screen coordinates and its underlying colour. One clock later the block returns either that colour unchanged or the chosen pointer colour.

The display timing and the colour table sit outside the block. The two pointer colours and the active screen width arrive as inputs. A miscellaneous register is also provided. It keeps whatever software writes to it, and when read back it always shows one status bit forced high.

Top module: `cursor_overlay`

## Requirements
- R1: After reset both pointer coordinates are 0xF000, every coverage and colour row is zero and the miscellaneous register is zero. As a result, no pixel on a normal screen is replaced.
- R2: A write to offset 0x8FC loads the pointer column from data bits 31:16 and the pointer line from data bits 15:0.
- R3: Coverage row r sits at offset 0x900+4r and colour row r at offset 0x980+4r, for r from 0 to 31. Row r applies to screen line Y+r, where Y is the pointer line.
- R4: Inside a row word, bit 31 is pointer column 0 (screen column X) and bit 31-c is pointer column c.
- R5: A covered pixel whose coverage bit is 1 takes input colour B when its colour bit is 1 and colour A when its colour bit is 0. A pixel whose coverage bit is 0 keeps its own colour.
- R6: Only screen lines Y through Y+31 and columns X through X+31 can be covered.
- R7: The pointer is drawn only when X is below the screen width. Pixels at a column equal to or greater than the width are never replaced.
- R8: A read of offset 0x818 returns the last value written there, ORed with bit 25 set.
- R9: A read of any other offset, including the position and row registers, returns zero. Read data appears on the clock after the read strobe.
- R10: The output valid flag and colour follow the input pixel by exactly one clock, and back-to-back pixels are accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| scr_width | input | 16 | Active screen width in pixels |
| col_a | input | 24 | Pointer colour used when the colour bit is 0 |
| col_b | input | 24 | Pointer colour used when the colour bit is 1 |
| pix_valid | input | 1 | Input pixel valid |
| pix_x | input | 16 | Input pixel column |
| pix_y | input | 16 | Input pixel line |
| pix_rgb | input | 24 | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_rgb | output | 24 | Output pixel colour |

## Verification
The overlay is tried in several ways:
- Single probes on each edge of the 32x32 window, one pixel inside and one outside. These separate off-by-one errors in the line and column windows.
- Rows whose first and last bits differ. These reveal a reversed bit order or a wrong row index.
- Narrowed screen widths, including a width equal to X. These separate clipping at the right edge from hiding the whole pointer.
- A long burst of back-to-back pixels at random coordinates around the pointer, compared against a behavioural model on every clock. This exposes latency or pipeline misalignment.
- Register reads of the miscellaneous register and of the other offsets. These tell the forced status bit apart from stored data.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  // byte offsets inside the register window
  localparam int OFF_MISC   = 'h818;
  localparam int OFF_POS    = 'h8FC;
  localparam int OFF_COVER  = 'h900;
  localparam int OFF_SHADE  = 'h980;
  // status bit forced high on miscellaneous reads
  localparam int MISC_FORCE = 25;
  // coordinate parked far outside any screen after reset
  localparam int PARK_COORD = 'hF000;
endpackage

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic [COORD_W-1:0]             cur_x,
  output logic [COORD_W-1:0]             cur_y,
  output logic [DATA_W-1:0][DATA_W-1:0]  cover_rows,
  output logic [DATA_W-1:0][DATA_W-1:0]  shade_rows
);
  localparam int ROWS  = DATA_W;
  localparam int IDX_W = $clog2(ROWS);
  localparam logic [ADDR_W-1:0] A_MISC   = ADDR_W'(OFF_MISC);
  localparam logic [ADDR_W-1:0] A_POS    = ADDR_W'(OFF_POS);
  localparam logic [ADDR_W-1:0] A_COV_LO = ADDR_W'(OFF_COVER);
  localparam logic [ADDR_W-1:0] A_COV_HI = ADDR_W'(OFF_COVER + 4 * ROWS);
  localparam logic [ADDR_W-1:0] A_SHD_LO = ADDR_W'(OFF_SHADE);
  localparam logic [ADDR_W-1:0] A_SHD_HI = ADDR_W'(OFF_SHADE + 4 * ROWS);

  function automatic logic [IDX_W-1:0] row_of(input logic [ADDR_W-1:0] a,
                                              input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] d;
    d = a - base;
    return d[IDX_W+1:2];
  endfunction

  logic [DATA_W-1:0] misc_q;
  logic              sel_misc, sel_pos, sel_cov, sel_shd;
  logic [DATA_W-1:0] rd_val;

  assign sel_misc = (addr == A_MISC);
  assign sel_pos  = (addr == A_POS);
  assign sel_cov  = (addr >= A_COV_LO) && (addr < A_COV_HI);
  assign sel_shd  = (addr >= A_SHD_LO) && (addr < A_SHD_HI);

  always_comb begin
    rd_val = '0;
    if (sel_misc) begin
      rd_val = misc_q;
      rd_val[MISC_FORCE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x      <= COORD_W'(PARK_COORD);
      cur_y      <= COORD_W'(PARK_COORD);
      cover_rows <= '0;
      shade_rows <= '0;
      misc_q     <= '0;
      rdata      <= '0;
    end else begin
      if (wr_en) begin
        if (sel_pos) begin
          cur_x <= wdata[DATA_W-1 -: COORD_W];
          cur_y <= wdata[COORD_W-1:0];
        end
        if (sel_cov)  cover_rows[row_of(addr, A_COV_LO)] <= wdata;
        if (sel_shd)  shade_rows[row_of(addr, A_SHD_LO)] <= wdata;
        if (sel_misc) misc_q <= wdata;
      end
      if (rd_en) rdata <= rd_val;
    end
  end

  // R2
  pos_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_pos) |=> (cur_x == $past(wdata[DATA_W-1 -: COORD_W]) &&
                            cur_y == $past(wdata[COORD_W-1:0])));
  // R8
  misc_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel_misc) |=> rdata[MISC_FORCE]);
  // R9
  other_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !sel_misc) |=> (rdata == '0));
endmodule

// File: rtl/cursor_hit.sv
module cursor_hit #(
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16
) (
  input  logic [COORD_W-1:0]             pix_x,
  input  logic [COORD_W-1:0]             pix_y,
  input  logic [COORD_W-1:0]             cur_x,
  input  logic [COORD_W-1:0]             cur_y,
  input  logic [COORD_W-1:0]             scr_width,
  input  logic [DATA_W-1:0][DATA_W-1:0]  cover_rows,
  input  logic [DATA_W-1:0][DATA_W-1:0]  shade_rows,
  output logic                           covered,
  output logic                           pick_b
);
  localparam int SPAN  = DATA_W;
  localparam int IDX_W = $clog2(SPAN);

  // offset of p from origin o; msb flags "outside the span"
  function automatic logic [IDX_W:0] span_off(input logic [COORD_W-1:0] p,
                                              input logic [COORD_W-1:0] o);
    logic [COORD_W:0] d;
    d = {1'b0, p} - {1'b0, o};
    if (d[COORD_W] || (d[COORD_W-1:0] >= COORD_W'(SPAN)))
      return {1'b1, {IDX_W{1'b0}}};
    return {1'b0, d[IDX_W-1:0]};
  endfunction

  logic [IDX_W:0]   off_x, off_y;
  logic             on_screen, in_box;
  logic [IDX_W-1:0] bit_sel;

  assign off_x     = span_off(pix_x, cur_x);
  assign off_y     = span_off(pix_y, cur_y);
  assign on_screen = (cur_x < scr_width) && (pix_x < scr_width);
  assign in_box    = !off_x[IDX_W] && !off_y[IDX_W];
  assign bit_sel   = IDX_W'(SPAN - 1) - off_x[IDX_W-1:0];
  assign covered   = on_screen && in_box &&
                     cover_rows[off_y[IDX_W-1:0]][bit_sel];
  assign pick_b    = shade_rows[off_y[IDX_W-1:0]][bit_sel];
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 16,
  parameter int RGB_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [COORD_W-1:0] scr_width,
  input  logic [RGB_W-1:0]   col_a,
  input  logic [RGB_W-1:0]   col_b,
  input  logic               pix_valid,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic [RGB_W-1:0]   pix_rgb,
  output logic               out_valid,
  output logic [RGB_W-1:0]   out_rgb
);
  logic [COORD_W-1:0]            cur_x, cur_y;
  logic [DATA_W-1:0][DATA_W-1:0] cover_rows, shade_rows;
  logic                          covered, pick_b;
  logic [RGB_W-1:0]              mix_rgb;

  cursor_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COORD_W(COORD_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cur_x(cur_x), .cur_y(cur_y),
    .cover_rows(cover_rows), .shade_rows(shade_rows)
  );

  cursor_hit #(.DATA_W(DATA_W), .COORD_W(COORD_W)) u_hit (
    .pix_x(pix_x), .pix_y(pix_y), .cur_x(cur_x), .cur_y(cur_y),
    .scr_width(scr_width), .cover_rows(cover_rows), .shade_rows(shade_rows),
    .covered(covered), .pick_b(pick_b)
  );

  assign mix_rgb = covered ? (pick_b ? col_b : col_a) : pix_rgb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_rgb <= mix_rgb;
    end
  end

  // R10
  lat_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  // R10
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> !out_valid);
  // R5
  pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !covered) |=> (out_rgb == $past(pix_rgb)));
  // R5
  pick_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && covered && pick_b) |=> (out_rgb == $past(col_b)));
  // R7
  clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (pix_x >= scr_width)) |=> (out_rgb == $past(pix_rgb)));
endmodule

// File: tb/test_cursor_overlay.sv
module test_cursor_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [15:0] scr_width = 16'd640;
  logic [23:0] col_a = 24'h00AA11, col_b = 24'hBB22CC;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_x = '0, pix_y = '0;
  logic [23:0] pix_rgb = '0;
  logic        out_valid;
  logic [23:0] out_rgb;

  int checks = 0, errors = 0, cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk;

  cursor_overlay i_cursor_overlay (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .scr_width(scr_width), .col_a(col_a),
    .col_b(col_b), .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .pix_rgb(pix_rgb), .out_valid(out_valid), .out_rgb(out_rgb)
  );

  // behavioural reference
  int          m_x, m_y;
  logic [31:0] m_cov [32];
  logic [31:0] m_shd [32];
  logic [31:0] m_misc;
  logic        e_valid;
  logic [23:0] e_rgb;
  logic        e_rd_due;
  logic [31:0] e_rd;

  function automatic logic [23:0] predict(int x, int y, logic [23:0] under);
    int dx, dy;
    dx = x - m_x;
    dy = y - m_y;
    if (m_x < int'(scr_width) && x < int'(scr_width) &&
        dx >= 0 && dx < 32 && dy >= 0 && dy < 32 && m_cov[dy][31-dx])
      return m_shd[dy][31-dx] ? col_b : col_a;
    return under;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_x = 'hF000; m_y = 'hF000; m_misc = 0;
      for (int i = 0; i < 32; i++) begin m_cov[i] = 0; m_shd[i] = 0; end
      e_valid <= 1'b0; e_rgb <= '0; e_rd_due <= 1'b0; e_rd <= '0;
    end else begin
      e_valid  <= pix_valid;
      if (pix_valid) e_rgb <= predict(int'(pix_x), int'(pix_y), pix_rgb);
      e_rd_due <= rd_en;
      if (rd_en) e_rd <= (int'(addr) == 'h818) ? (m_misc | 32'h0200_0000) : 32'h0;
      if (wr_en) begin
        if (addr == 12'h8FC) begin m_x = int'(wdata[31:16]); m_y = int'(wdata[15:0]); end
        else if (addr == 12'h818) m_misc = wdata;
        else if (addr >= 12'h900 && addr < 12'h980) m_cov[(int'(addr) - 'h900) / 4] = wdata;
        else if (addr >= 12'h980 && addr < 12'hA00) m_shd[(int'(addr) - 'h980) / 4] = wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== e_valid || (e_valid && out_rgb !== e_rgb)) begin
        errors++;
        $display("FAIL %s pixel: valid=%b rgb=%h expected valid=%b rgb=%h",
                 tag, out_valid, out_rgb, e_valid, e_rgb);
      end
      if (e_rd_due) begin
        checks++;
        if (rdata !== e_rd) begin
          errors++;
          $display("FAIL %s read: rdata=%h expected %h", tag, rdata, e_rd);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected < 50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic px(input int x, input int y);
    pix_valid = 1'b1; pix_x = 16'(x); pix_y = 16'(y);
    pix_rgb = {8'(x), 8'(y), 8'h5A};
    @(negedge clk);
    pix_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    tag = "R1";
    checks++;
    if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
      errors++;
      $display("FAIL R1 reset: valid=%b rgb=%h expected 0/000000", out_valid, out_rgb);
    end
    px(0, 0); px(100, 100);
    rd(12'h818);
    // R8: misc store plus forced bit
    tag = "R8";
    wr(12'h818, 32'h00A5_00F1);
    rd(12'h818);
    // R9: other offsets read zero
    tag = "R9";
    wr(12'h8FC, {16'd10, 16'd20});
    rd(12'h8FC); rd(12'h900); rd(12'h004);
    // R2/R3: program rows
    tag = "R2/R3";
    wr(12'h900, 32'h8000_0001);
    wr(12'h980, 32'h8000_0000);
    wr(12'h97C, 32'hFFFF_FFFF);
    wr(12'h9FC, 32'h0000_FFFF);
    wr(12'h940, 32'h0F0F_0F0F);
    wr(12'h9C0, 32'h00FF_00FF);
    rd(12'h97C);
    // R4/R5: bit order and colour choice
    tag = "R4/R5";
    px(10, 20); px(41, 20); px(11, 20); px(40, 20);
    px(10, 51); px(41, 51); px(25, 51);
    // R6: window edges
    tag = "R6";
    px(9, 20); px(42, 20); px(10, 19); px(10, 52); px(41, 52);
    for (int x = 0; x < 50; x++) px(x, 36);
    // R7: right-edge clipping
    tag = "R7";
    scr_width = 16'd30;
    px(10, 20); px(41, 20); px(29, 51); px(30, 51);
    scr_width = 16'd10;
    px(10, 20); px(10, 51);
    scr_width = 16'd11;
    px(10, 20);
    scr_width = 16'd640;
    // R2: move pointer and retest
    tag = "R2";
    wr(12'h8FC, {16'd200, 16'd5});
    px(200, 5); px(231, 5); px(10, 20);
    // R10: back-to-back stream
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      pix_valid = ($urandom_range(0, 3) != 0);
      pix_x = 16'($urandom_range(190, 240));
      pix_y = 16'($urandom_range(0, 40));
      pix_rgb = 24'($urandom);
      @(negedge clk);
    end
    pix_valid = 1'b0;
    // R1: reset again parks the pointer
    tag = "R1";
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    px(200, 5); px(10, 20);
    rd(12'h818);
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule